// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is one 8-bit peripheral port that sends and receives over a single set of pins, using two handshake pairs. On the transmit side, the CPU writes a byte into an output latch. The active-low buffer-full flag then drops. The pin drivers are enabled only while the peripheral holds its acknowledge line low. When the acknowledge is seen, the flag goes high again and the transfer is marked complete. On the receive side, the peripheral pulls a strobe low to load the pin levels into a separate input latch. This raises an input-full flag, which the CPU clears by reading.

One active-high interrupt line serves both directions. Each direction has its own enable flip-flop. The CPU sets or clears these flip-flops with single-bit commands addressed to bit positions of a companion control port. Bit 6 controls the transmit enable and bit 4 controls the receive enable. Commands to any other bit position leave both enables unchanged. The strobe and acknowledge inputs pass through a configurable synchronizer before they reach the handshake logic. CPU address decoding is outside the block.

Top module: `sbp_port`

## Requirements
- R1: After reset, obf_n is 1, ibf is 0, intr is 0, pin_o is 0 and cpu_rdata is 0.
- R2: A one-cycle cpu_wr pulse loads cpu_wdata into the output latch, which appears on pin_o. It also drives obf_n low after the next clock edge.
- R3: pin_oe is high exactly while ack_n is low, with no clock delay; otherwise the pins are left undriven.
- R4: While obf_n is low, the synchronized ack_n being low sets obf_n back to 1 and marks the transmit as done. A write in the same cycle takes precedence.
- R5: While the synchronized stb_n is low, the input latch captures pin_i each clock and ibf goes to 1. The latched byte is visible on cpu_rdata.
- R6: A cpu_rd pulse clears ibf. If the synchronized strobe is low in the same cycle, ibf stays 1.
- R7: intr = (transmit enable AND transmit done AND synchronized ack_n high) OR (receive enable AND ibf AND synchronized stb_n high).
- R8: A valid bit command with cmd_sel = 6 sets the transmit enable when cmd_set = 1 and clears it when cmd_set = 0. With cmd_sel = 4 it does the same for the receive enable. Any other cmd_sel value changes neither enable. Both enables reset to 0.
- R9: A cpu_wr clears the transmit-done condition, so the transmit share of intr drops.
- R10: A strobe never alters the output latch: pin_o keeps the last written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | One-cycle CPU write of the output latch |
| cpu_wdata | input | 8 | Byte to transmit |
| cpu_rd | input | 1 | One-cycle CPU read of the input latch |
| cpu_rdata | output | 8 | Content of the input latch |
| cmd_valid | input | 1 | Bit command strobe |
| cmd_sel | input | 3 | Bit position addressed by the command |
| cmd_set | input | 1 | 1 sets, 0 clears the addressed bit |
| pin_i | input | 8 | Levels sampled from the shared pins |
| pin_o | output | 8 | Output latch driven to the shared pins |
| pin_oe | output | 1 | Pin driver enable |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Merged interrupt request |

## Verification
The assertions check the following on every cycle: the write and drain transitions of the transmit flag, the load and clear of the receive flag with strobe priority, the holding of both latches, the immunity of the enables to unrelated bit commands, and that intr never rises without a pending flag. Some behaviour can only be shown by the bench's scenarios: the masking of intr while a handshake line is still low, the combined effect of the synchronizer latency across whole pulses, and the independence of the two latches under mixed random traffic.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

   typedef enum logic {
      BIT_CLR = 1'b0,
      BIT_SET = 1'b1
   } bit_op_e;

   // One interrupt contribution: enabled, pending, handshake line released.
   function automatic logic irq_term(input logic en, input logic flag, input logic line_hi);
      return en & flag & line_hi;
   endfunction

endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("sbp_sync: STAGES must be >= 0");
   end

   if (STAGES == 0) begin : g_direct
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               chain[i] <= chain[i-1];
            end
         end
      end
      assign q = chain[STAGES-1];
   end

endmodule

// File: rtl/sbp_tx.sv
module sbp_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack_s,
   output logic [DATA_W-1:0] out_data,
   output logic              full,
   output logic              done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data <= '0;
         full     <= 1'b0;
         done     <= 1'b0;
      end else if (wr) begin
         out_data <= wdata;
         full     <= 1'b1;
         done     <= 1'b0;
      end else if (full && !ack_s) begin
         full     <= 1'b0;
         done     <= 1'b1;
      end
   end

   a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (full && out_data == $past(wdata)));
   a_r4_ack_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !ack_s && !wr) |=> (!full && done));
   a_r9_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !done);
   a_r10_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(out_data));

endmodule

// File: rtl/sbp_rx.sv
module sbp_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              stb_s,
   input  logic [DATA_W-1:0] pins,
   output logic [DATA_W-1:0] in_data,
   output logic              full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_data <= '0;
         full    <= 1'b0;
      end else if (!stb_s) begin
         in_data <= pins;
         full    <= 1'b1;
      end else if (rd) begin
         full    <= 1'b0;
      end
   end

   a_r5_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_s |=> (full && in_data == $past(pins)));
   a_r6_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && stb_s) |=> !full);
   a_r6_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
      stb_s |=> $stable(in_data));

endmodule

// File: rtl/sbp_irq.sv
module sbp_irq
   import sbp_pkg::*;
#(
   parameter int CTRL_BITS  = 8,
   parameter int OUT_EN_BIT = 6,
   parameter int IN_EN_BIT  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [$clog2(CTRL_BITS)-1:0] cmd_sel,
   input  bit_op_e                      cmd_op,
   input  logic                         tx_done,
   input  logic                         ack_s,
   input  logic                         rx_full,
   input  logic                         stb_s,
   output logic                         irq
);

   localparam int SEL_W = $clog2(CTRL_BITS);
   localparam logic [SEL_W-1:0] OUT_SEL = SEL_W'(OUT_EN_BIT);
   localparam logic [SEL_W-1:0] IN_SEL  = SEL_W'(IN_EN_BIT);

   logic en_out, en_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_out <= 1'b0;
         en_in  <= 1'b0;
      end else if (cmd_valid) begin
         if (cmd_sel == OUT_SEL) en_out <= (cmd_op == BIT_SET);
         if (cmd_sel == IN_SEL)  en_in  <= (cmd_op == BIT_SET);
      end
   end

   assign irq = irq_term(en_out, tx_done, ack_s) | irq_term(en_in, rx_full, stb_s);

   a_r8_other_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_sel != OUT_SEL && cmd_sel != IN_SEL) |=> ($stable(en_out) && $stable(en_in)));
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(en_out) && $stable(en_in)));
   a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_out || en_in));

endmodule

// File: rtl/sbp_port.sv
module sbp_port
   import sbp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CTRL_BITS   = 8,
   parameter int OUT_EN_BIT  = 6,
   parameter int IN_EN_BIT   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cpu_wr,
   input  logic [DATA_W-1:0]            cpu_wdata,
   input  logic                         cpu_rd,
   output logic [DATA_W-1:0]            cpu_rdata,
   input  logic                         cmd_valid,
   input  logic [$clog2(CTRL_BITS)-1:0] cmd_sel,
   input  logic                         cmd_set,
   input  logic [DATA_W-1:0]            pin_i,
   output logic [DATA_W-1:0]            pin_o,
   output logic                         pin_oe,
   input  logic                         ack_n,
   input  logic                         stb_n,
   output logic                         obf_n,
   output logic                         ibf,
   output logic                         intr
);

   if (DATA_W < 1) begin : g_bad_width
      $error("sbp_port: DATA_W must be positive");
   end
   if (CTRL_BITS < 2) begin : g_bad_ctrl
      $error("sbp_port: CTRL_BITS must be at least 2");
   end
   if (OUT_EN_BIT < 0 || OUT_EN_BIT >= CTRL_BITS || IN_EN_BIT < 0 || IN_EN_BIT >= CTRL_BITS) begin : g_bad_bit
      $error("sbp_port: enable bit positions out of range");
   end
   if (OUT_EN_BIT == IN_EN_BIT) begin : g_same_bit
      $error("sbp_port: enable bit positions must differ");
   end

   logic ack_s, stb_s;
   logic tx_full, tx_done, rx_full;

   sbp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_s));

   sbp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .d(stb_n), .q(stb_s));

   sbp_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .wdata(cpu_wdata), .ack_s(ack_s),
      .out_data(pin_o), .full(tx_full), .done(tx_done));

   sbp_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .stb_s(stb_s), .pins(pin_i),
      .in_data(cpu_rdata), .full(rx_full));

   sbp_irq #(.CTRL_BITS(CTRL_BITS), .OUT_EN_BIT(OUT_EN_BIT), .IN_EN_BIT(IN_EN_BIT)) u_irq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
      .cmd_op(bit_op_e'(cmd_set)), .tx_done(tx_done), .ack_s(ack_s),
      .rx_full(rx_full), .stb_s(stb_s), .irq(intr));

   assign pin_oe = ~ack_n;
   assign obf_n  = ~tx_full;
   assign ibf    = rx_full;

   a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> (ibf || obf_n));
   a_r9_write_drops_tx_share: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !ibf) |=> !intr);

endmodule

// File: tb/sbp_port_bench.sv
module sbp_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = '0, cpu_rdata;
   logic       cmd_valid = 1'b0, cmd_set = 1'b0;
   logic [2:0] cmd_sel = '0;
   logic [7:0] pin_i = '0, pin_o;
   logic       pin_oe, ack_n = 1'b1, stb_n = 1'b1;
   logic       obf_n, ibf, intr;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   // model state
   bit m_obf, m_done, m_ibf, m_ie_o, m_ie_i;
   logic [7:0] m_olat, m_ilat;

   always #2 clk = ~clk;

   sbp_port u_sbp_port (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cmd_valid(cmd_valid),
      .cmd_sel(cmd_sel), .cmd_set(cmd_set), .pin_i(pin_i), .pin_o(pin_o),
      .pin_oe(pin_oe), .ack_n(ack_n), .stb_n(stb_n), .obf_n(obf_n),
      .ibf(ibf), .intr(intr));

   function automatic bit exp_intr(bit ack_hi, bit stb_hi);
      return (m_ie_o & m_done & ack_hi) | (m_ie_i & m_ibf & stb_hi);
   endfunction

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(logic [7:0] d);
      @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
      @(negedge clk); cpu_wr = 1'b0;
      m_olat = d; m_obf = 1; m_done = 0;
   endtask

   task automatic do_read();
      @(negedge clk); cpu_rd = 1'b1;
      @(negedge clk); cpu_rd = 1'b0;
      m_ibf = 0;
   endtask

   task automatic do_cmd(logic [2:0] sel, logic set);
      @(negedge clk); cmd_valid = 1'b1; cmd_sel = sel; cmd_set = set;
      @(negedge clk); cmd_valid = 1'b0;
      if (sel == 3'd6) m_ie_o = set;
      if (sel == 3'd4) m_ie_i = set;
   endtask

   task automatic do_ack();
      @(negedge clk); ack_n = 1'b0;
      #1 check("R3 oe on ack", int'(pin_oe), 1);
      idle(4);
      if (m_obf) begin m_obf = 0; m_done = 1; end
      check("R7 intr masked while ack low", int'(intr), int'(exp_intr(0, 1)));
      check("R4 obf_n during ack", int'(obf_n), 1);
      ack_n = 1'b1;
      idle(4);
   endtask

   task automatic do_strobe(logic [7:0] d);
      @(negedge clk); stb_n = 1'b0; pin_i = d;
      idle(4);
      m_ilat = d; m_ibf = 1;
      check("R7 intr masked while stb low", int'(intr), int'(exp_intr(1, 0)));
      stb_n = 1'b1;
      idle(4);
      pin_i = ~d;
   endtask

   task automatic check_idle(string tag);
      check({tag, " R4 obf_n"}, int'(obf_n), int'(!m_obf));
      check({tag, " R6 ibf"}, int'(ibf), int'(m_ibf));
      check({tag, " R7 intr"}, int'(intr), int'(exp_intr(1, 1)));
      check({tag, " R5 rdata"}, int'(cpu_rdata), int'(m_ilat));
      check({tag, " R10 pin_o"}, int'(pin_o), int'(m_olat));
      check({tag, " R3 oe off"}, int'(pin_oe), 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      m_obf = 0; m_done = 0; m_ibf = 0; m_ie_o = 0; m_ie_i = 0;
      m_olat = '0; m_ilat = '0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      check("R1 obf_n", int'(obf_n), 1);
      check("R1 ibf", int'(ibf), 0);
      check("R1 intr", int'(intr), 0);
      check("R1 pin_o", int'(pin_o), 0);
      check("R1 rdata", int'(cpu_rdata), 0);

      // R2 write fills, then R4 drain, R8 enable, R7 intr, R9 write clears
      do_write(8'hA5);
      check("R2 obf_n low", int'(obf_n), 0);
      check("R2 pin_o", int'(pin_o), 8'hA5);
      do_cmd(3'd6, 1'b1);
      do_ack();
      check("R4 obf_n high", int'(obf_n), 1);
      check("R7 tx intr", int'(intr), 1);
      do_write(8'h3C);
      check("R9 intr dropped", int'(intr), 0);

      // R10 strobe leaves output latch; R5 load
      do_strobe(8'h5A);
      check("R10 pin_o kept", int'(pin_o), 8'h3C);
      check("R5 ibf", int'(ibf), 1);
      check("R5 rdata", int'(cpu_rdata), 8'h5A);
      check("R7 rx disabled", int'(intr), 0);
      // R8 unrelated bits change nothing
      for (int b = 0; b < 8; b++) begin
         if (b != 4 && b != 6) do_cmd(3'(b), 1'b1);
      end
      check("R8 other bits ignored", int'(intr), 0);
      do_cmd(3'd4, 1'b1);
      check("R8 rx enable", int'(intr), 1);

      // R6 read during live strobe: set wins
      @(negedge clk); stb_n = 1'b0; pin_i = 8'h77;
      idle(3);
      cpu_rd = 1'b1;
      @(negedge clk); cpu_rd = 1'b0;
      idle(1);
      stb_n = 1'b1;
      idle(4);
      m_ilat = 8'h77; m_ibf = 1;
      check("R6 strobe beats read", int'(ibf), 1);
      do_read();
      check("R6 read clears", int'(ibf), 0);
      check_idle("directed");

      // random mix
      for (int it = 0; it < 400; it++) begin
         case ($urandom_range(0, 4))
            0: do_write(8'($urandom));
            1: do_ack();
            2: do_strobe(8'($urandom));
            3: do_read();
            default: do_cmd(3'($urandom_range(0, 7)), 1'($urandom));
         endcase
         idle(1);
         check_idle("random");
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule